// File: doc/BRIEF.md
# Calendar Real-Time Clock with BCD Year

This block keeps wall-clock time directly as calendar fields rather than as a running count of seconds. A 32-bit time word packs seconds, minutes, hours, weekday, day of month and month. A separate 16-bit register holds the year as four BCD digits: the century in the upper byte and the year within the century in the lower byte. A 32768 Hz tick strobe, synchronous to the system clock, is divided down to one step per second. Each step carries through every field, taking month lengths and leap years into account.

Software controls the block through a small register port. A run bit enables counting. The year is first staged in a load register and is applied together with the time word when the time load register is written, which also restarts the sub-second divider. Two match registers hold an alarm date and time, and the alarm output goes high one clock after both the time word and the year equal them exactly. All control pins are plain levels and strobes. No stream interface is involved, so there is no back-pressure.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time word reads 0x021E0000 (1 January, weekday 7 = Saturday, 00:00:00), the year reads 0x2000, the control register reads 0 and alarm_o is low.
- R2: Time word fields are: seconds in bits 5:0, minutes in 11:6, hours in 16:12, weekday in 19:17 (1 = Sunday … 7 = Saturday), day of month in 24:20, and month in 28:25 (1 = January). Bits 31:29 read as zero.
- R3: Counting is enabled only while control bit 26 is set. The time then advances by one second after exactly TICKS_PER_SEC tick_i strobes. With the bit clear, ticks have no effect.
- R4: Seconds and minutes roll over from 59 to 0 and hours from 23 to 0, each carrying into the next field.
- R5: Each new day advances the weekday by one, and weekday 7 is followed by 1.
- R6: April, June, September and November end after day 30. The other months except February end after day 31. The day of month then returns to 1 and the month advances.
- R7: February has 29 days when the year is divisible by 4, except that a century year must be divisible by 400. Otherwise it has 28 days.
- R8: After 31 December the month returns to 1 and the BCD year increments with decimal digit carry; 9999 wraps to 0000.
- R9: A write to the year load register (0x38) changes nothing visible in the running year. The next write to the time load register (0x08) loads the time word and the staged year on the same edge and restarts the one-second divider.
- R10: Register offsets: 0x00 current time, 0x04 time match, 0x08 time load (reads current time), 0x0C control, 0x30 current year, 0x34 year match, 0x38 staged year. Other offsets read 0.
- R11: alarm_o is high in the cycle after the time word equals the time match and the year equals the year match. It is low when either word differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per 32768 Hz period |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| alarm_o | output | 1 | High while the full date and time equal the match registers |

## Verification
On every cycle the assertions check the following. A second step can happen only while running. The time word and the year hold unless a step or a load occurs. A load applies the written word and the staged year on the next edge. A step below 59 seconds adds exactly one second. The alarm never rises while the years differ. Month lengths, leap-year rules, weekday wrap, BCD carry into the century and the 9999 wrap depend on specific dates, so only the bench's directed and random scenarios can show them. Those scenarios check every result against a calendar model computed from the requirements.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int ADDR_W   = 6;
  localparam int WORD_W   = 32;
  localparam int YEAR_W   = 16;
  localparam int RUN_BIT  = 26;

  localparam logic [ADDR_W-1:0] OFF_NOW_TIME   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_ALM_TIME   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_SET_TIME   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CONTROL    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_NOW_YEAR   = 6'h30;
  localparam logic [ADDR_W-1:0] OFF_ALM_YEAR   = 6'h34;
  localparam logic [ADDR_W-1:0] OFF_SET_YEAR   = 6'h38;

  // Packed calendar word, msb first (sec occupies bits 5:0)
  typedef struct packed {
    logic [2:0] pad;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_word_t;

  localparam logic [WORD_W-1:0] FIELD_MASK = 32'h1FFF_FFFF;
  localparam logic [YEAR_W-1:0] YEAR_AT_RESET = 16'h2000;

  localparam cal_word_t WORD_AT_RESET = '{pad: 3'd0, mon: 4'd1, mday: 5'd1,
                                          wday: 3'd7, hour: 5'd0, min: 6'd0,
                                          sec: 6'd0};

  // BCD pair divisible by four: even tens with units 0/4/8, odd tens with 2/6
  function automatic logic bcd_pair_div4(input logic [7:0] pair);
    logic [3:0] u;
    u = pair[3:0];
    if (!pair[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    return (u == 4'd2) || (u == 4'd6);
  endfunction

  function automatic logic bcd_leap(input logic [YEAR_W-1:0] y);
    if (y[7:0] == 8'h00) return bcd_pair_div4(y[15:8]);
    return bcd_pair_div4(y[7:0]);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic sec_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] phase_q;

  assign sec_o = run_i && tick_i && (phase_q == LAST) && !clear_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) begin
      phase_q <= '0;
    end else if (run_i && tick_i) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + CW'(1);
    end
  end
endmodule

// File: rtl/rtc_bcd_year.sv
module rtc_bcd_year #(
  parameter int DIGITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [4*DIGITS-1:0]  load_val_i,
  input  logic                 step_i,
  output logic [4*DIGITS-1:0]  year_o
);
  logic [4*DIGITS-1:0] year_q, year_inc;
  logic [DIGITS:0]     carry;

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] d;
    assign d = year_q[4*g +: 4];
    assign carry[g+1] = carry[g] && (d >= 4'd9);
    assign year_inc[4*g +: 4] = !carry[g] ? d : ((d >= 4'd9) ? 4'd0 : d + 4'd1);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      year_q <= (4*DIGITS)'(rtc_cal_pkg::YEAR_AT_RESET);
    else if (load_i)  year_q <= load_val_i;
    else if (step_i)  year_q <= year_inc;
  end

  assign year_o = year_q;
endmodule

// File: rtl/rtc_cal_fields.sv
module rtc_cal_fields
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              step_i,
  input  logic              leap_i,
  output logic [WORD_W-1:0] word_o,
  output logic              year_step_o
);
  cal_word_t cur_q, nxt;
  logic      wrap_year;
  logic [4:0] last_day;

  assign last_day = month_days(cur_q.mon, leap_i);

  always_comb begin
    nxt       = cur_q;
    wrap_year = 1'b0;
    if (cur_q.sec < 6'd59) begin
      nxt.sec = cur_q.sec + 6'd1;
    end else begin
      nxt.sec = '0;
      if (cur_q.min < 6'd59) begin
        nxt.min = cur_q.min + 6'd1;
      end else begin
        nxt.min = '0;
        if (cur_q.hour < 5'd23) begin
          nxt.hour = cur_q.hour + 5'd1;
        end else begin
          nxt.hour = '0;
          nxt.wday = (cur_q.wday >= 3'd7) ? 3'd1 : cur_q.wday + 3'd1;
          if (cur_q.mday < last_day) begin
            nxt.mday = cur_q.mday + 5'd1;
          end else begin
            nxt.mday = 5'd1;
            if (cur_q.mon < 4'd12) begin
              nxt.mon = cur_q.mon + 4'd1;
            end else begin
              nxt.mon   = 4'd1;
              wrap_year = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cur_q <= WORD_AT_RESET;
    else if (load_i)  cur_q <= cal_word_t'(load_word_i & FIELD_MASK);
    else if (step_i)  cur_q <= nxt;
  end

  assign word_o      = cur_q;
  assign year_step_o = step_i && !load_i && wrap_year;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              alarm_o
);
  logic              run_q;
  logic [WORD_W-1:0] match_time_q;
  logic [YEAR_W-1:0] match_year_q, year_pend_q;
  logic [WORD_W-1:0] time_word;
  logic [YEAR_W-1:0] year_val;
  logic              sec_pulse, year_step, time_load, alarm_q;

  assign time_load = reg_we_i && (reg_addr_i == OFF_SET_TIME);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      match_time_q <= '0;
      match_year_q <= '0;
      year_pend_q  <= YEAR_AT_RESET;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        OFF_CONTROL:  run_q        <= reg_wdata_i[RUN_BIT];
        OFF_ALM_TIME: match_time_q <= reg_wdata_i & FIELD_MASK;
        OFF_ALM_YEAR: match_year_q <= reg_wdata_i[YEAR_W-1:0];
        OFF_SET_YEAR: year_pend_q  <= reg_wdata_i[YEAR_W-1:0];
        default: ;
      endcase
    end
  end

  rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(time_load),
    .run_i(run_q), .tick_i(tick_i), .sec_o(sec_pulse)
  );

  rtc_cal_fields u_fields (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(time_load),
    .load_word_i(reg_wdata_i), .step_i(sec_pulse),
    .leap_i(bcd_leap(year_val)), .word_o(time_word),
    .year_step_o(year_step)
  );

  rtc_bcd_year #(.DIGITS(YEAR_W/4)) u_year (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(time_load),
    .load_val_i(year_pend_q), .step_i(year_step), .year_o(year_val)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= (time_word == match_time_q) && (year_val == match_year_q);
  end
  assign alarm_o = alarm_q;

  always_comb begin
    case (reg_addr_i)
      OFF_NOW_TIME, OFF_SET_TIME: reg_rdata_o = time_word;
      OFF_ALM_TIME: reg_rdata_o = match_time_q;
      OFF_CONTROL:  reg_rdata_o = WORD_W'(run_q) << RUN_BIT;
      OFF_NOW_YEAR: reg_rdata_o = WORD_W'(year_val);
      OFF_ALM_YEAR: reg_rdata_o = WORD_W'(match_year_q);
      OFF_SET_YEAR: reg_rdata_o = WORD_W'(year_pend_q);
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sec_pulse,
  input logic              time_load,
  input logic              run,
  input logic              year_step,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] time_word,
  input logic [YEAR_W-1:0] year_val,
  input logic [YEAR_W-1:0] year_pend,
  input logic [YEAR_W-1:0] match_year,
  input logic              alarm
);
  // R3
  step_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse |-> run);

  // R3
  time_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_pulse && !time_load) |=> $stable(time_word));

  // R8
  year_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!year_step && !time_load) |=> $stable(year_val));

  // R9
  load_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load |=> time_word == ($past(wdata) & FIELD_MASK));

  // R9
  load_year_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load |=> year_val == $past(year_pend));

  // R4
  sec_increment_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && !time_load && time_word[5:0] < 6'd59)
      |=> time_word[5:0] == 6'($past(time_word[5:0]) + 6'd1));

  // R11
  alarm_year_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm) |-> $past(year_val == match_year));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sec_pulse(sec_pulse),
  .time_load(time_load), .run(run_q), .year_step(year_step),
  .wdata(reg_wdata_i), .time_word(time_word), .year_val(year_val),
  .year_pend(year_pend_q), .match_year(match_year_q), .alarm(alarm_o)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = 6'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        alarm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(N)) u_rtc_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .alarm_o(alarm)
  );

  function automatic logic [31:0] mk(int mon, int md, int wd, int h, int mi, int s);
    return (32'(mon) << 25) | (32'(md) << 20) | (32'(wd) << 17) |
           (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
  endfunction

  function automatic int from_bcd(logic [15:0] y);
    return y[15:12]*1000 + y[11:8]*100 + y[7:4]*10 + y[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(int v);
    return {4'(v/1000), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
  endfunction

  function automatic int dim(int mon, int yr);
    bit leap;
    leap = ((yr % 4 == 0) && (yr % 100 != 0)) || (yr % 400 == 0);
    if (mon == 2) return leap ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  // Reference calendar: returns {year_bcd, time_word} one second later
  function automatic logic [47:0] one_sec(logic [31:0] t, logic [15:0] yb);
    int s, mi, h, wd, md, mo, yr;
    s = int'(t[5:0]); mi = int'(t[11:6]); h = int'(t[16:12]);
    wd = int'(t[19:17]); md = int'(t[24:20]); mo = int'(t[28:25]);
    yr = from_bcd(yb);
    s++;
    if (s == 60) begin s = 0; mi++; end
    if (mi == 60) begin mi = 0; h++; end
    if (h == 24) begin
      h = 0; wd = (wd == 7) ? 1 : wd + 1; md++;
      if (md > dim(mo, yr)) begin md = 1; mo++; end
      if (mo == 13) begin mo = 1; yr = (yr + 1) % 10000; end
    end
    return {to_bcd(yr), mk(mo, md, wd, h, mi, s)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(logic [31:0] t, logic [15:0] y);
    wr(6'h38, 32'(y));
    wr(6'h08, t);
  endtask

  task automatic step_check(string tag, logic [31:0] t, logic [15:0] y);
    logic [47:0] exp;
    logic [31:0] v;
    exp = one_sec(t, y);
    load(t, y);
    ticks(N);
    rd(6'h00, v); check({tag, " time"}, v, exp[31:0]);
    rd(6'h30, v); check({tag, " year"}, v, 32'(exp[47:32]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 reset state: 1 Jan, Saturday(7), midnight
    rd(6'h00, v); check("R1 R2 reset time", v, 32'h021E_0000);
    rd(6'h30, v); check("R1 reset year", v, 32'h2000);
    rd(6'h0C, v); check("R1 reset control", v, 0);
    check("R1 reset alarm", 32'(alarm), 0);

    // R10 register map
    wr(6'h04, mk(3, 4, 5, 6, 7, 8));
    rd(6'h04, v); check("R10 time match readback", v, mk(3, 4, 5, 6, 7, 8));
    wr(6'h34, 32'h1999);
    rd(6'h34, v); check("R10 year match readback", v, 32'h1999);
    rd(6'h3C, v); check("R10 unmapped reads zero", v, 0);

    // R3 no counting while stopped
    ticks(3 * N);
    rd(6'h00, v); check("R3 stopped time unchanged", v, 32'h021E_0000);
    wr(6'h0C, 32'h0400_0000);
    rd(6'h0C, v); check("R10 control readback", v, 32'h0400_0000);
    ticks(N - 1);
    rd(6'h00, v); check("R3 before last tick", v, 32'h021E_0000);
    ticks(1);
    rd(6'h00, v); check("R3 one second", v, 32'h021E_0001);

    // R9 staged year and divider restart
    wr(6'h38, 32'h2024);
    rd(6'h30, v); check("R9 staged year not applied", v, 32'h2000);
    rd(6'h38, v); check("R10 staged year readback", v, 32'h2024);
    ticks(N - 1);
    wr(6'h08, mk(6, 10, 2, 12, 30, 0));
    rd(6'h30, v); check("R9 year applied on time load", v, 32'h2024);
    ticks(N - 1);
    rd(6'h00, v); check("R9 divider restarted", v, mk(6, 10, 2, 12, 30, 0));
    ticks(1);
    rd(6'h00, v); check("R9 step after full period", v, mk(6, 10, 2, 12, 30, 1));

    // R4 .. R8 directed corners
    step_check("R4 minute carry", mk(5, 5, 3, 10, 20, 59), 16'h2030);
    step_check("R4 day carry", mk(5, 5, 3, 23, 59, 59), 16'h2030);
    step_check("R5 weekday wrap", mk(5, 9, 7, 23, 59, 59), 16'h2030);
    step_check("R6 april end", mk(4, 30, 1, 23, 59, 59), 16'h2031);
    step_check("R6 january end", mk(1, 31, 4, 23, 59, 59), 16'h2031);
    step_check("R7 feb 2024 leap", mk(2, 28, 4, 23, 59, 59), 16'h2024);
    step_check("R7 feb 29 end", mk(2, 29, 5, 23, 59, 59), 16'h2024);
    step_check("R7 feb 2100 common", mk(2, 28, 1, 23, 59, 59), 16'h2100);
    step_check("R7 feb 2000 leap", mk(2, 28, 2, 23, 59, 59), 16'h2000);
    step_check("R7 feb 2023 common", mk(2, 28, 3, 23, 59, 59), 16'h2023);
    step_check("R8 new year", mk(12, 31, 6, 23, 59, 59), 16'h1999);
    step_check("R8 century carry", mk(12, 31, 5, 23, 59, 59), 16'h2099);
    step_check("R8 wrap to zero", mk(12, 31, 6, 23, 59, 59), 16'h9999);
    rd(6'h30, v); check("R8 explicit 0000", v, 32'h0000);

    // R11 alarm
    wr(6'h04, mk(7, 14, 3, 8, 0, 0));
    wr(6'h34, 32'h2031);
    load(mk(7, 14, 3, 7, 59, 59), 16'h2031);
    @(negedge clk);
    check("R11 alarm low before match", 32'(alarm), 0);
    ticks(N);
    @(negedge clk);
    check("R11 alarm on match", 32'(alarm), 1);
    ticks(N);
    @(negedge clk);
    check("R11 alarm clears after", 32'(alarm), 0);
    wr(6'h34, 32'h2032);
    load(mk(7, 14, 3, 7, 59, 59), 16'h2031);
    ticks(N);
    @(negedge clk);
    check("R11 year mismatch no alarm", 32'(alarm), 0);

    // Random dates biased to rollover points
    for (int i = 0; i < 60; i++) begin
      int yr, mo, md, wd, h, mi, s;
      yr = int'($urandom_range(0, 9999));
      if ($urandom_range(0, 3) == 0) yr = 100 * int'($urandom_range(0, 99));
      mo = int'($urandom_range(1, 12));
      md = ($urandom_range(0, 1) == 1) ? dim(mo, yr) : int'($urandom_range(1, dim(mo, yr)));
      wd = int'($urandom_range(1, 7));
      h  = ($urandom_range(0, 2) != 0) ? 23 : int'($urandom_range(0, 23));
      mi = ($urandom_range(0, 2) != 0) ? 59 : int'($urandom_range(0, 59));
      s  = ($urandom_range(0, 2) != 0) ? 59 : int'($urandom_range(0, 59));
      step_check("R4 R5 R6 R7 R8 random", mk(mo, md, wd, h, mi, s), to_bcd(yr));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule